// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block keeps the calendar time in BCD: seconds, minutes, hours, day of month, month, a low and a high year byte, and a weekday. It advances by one second on each pulse of `tick_1hz`. That pulse is a single-cycle enable already brought into the bus clock domain from the slow oscillator domain. Software reaches the block through a flat 32-bit register bus. Writes take effect in the clock cycle of `bus_wr`. Reads are combinational from `bus_addr`. The bus always accepts a transfer and never applies back-pressure.

Software controls the counter with a run bit. A running-status bit follows the run bit on the next tick. Software polls that status bit before it loads a new time, and the loaded time starts counting after the next start. A snapshot command copies the live time into a shadow set, and a read-select bit makes the time registers return that copy. An alarm comparator checks seven fields (all except the weekday) against each newly advanced time. On a full match it sets a sticky pending bit, which can drive the interrupt line.

Register word offsets:

- 0x00 to 0x1C: the eight time fields.
- 0x20 to 0x38: the seven alarm fields.
- 0x3C: control.
- 0x40: event status.
- 0x44: run status.
- 0x48: interrupt enable.

Top module: `bcd_calendar_rtc`

## Requirements
- R1: A write is accepted only when `bus_wdata[31:8]` equals 0xC45229 and `bus_addr[1:0]` is 0. Any other write changes no register.
- R2: Run status (bit 0 of offset 0x44) takes the value of control bit 0 on the next tick. The time advances only on ticks where run status is already 1.
- R3: Time registers are writable only while run status is 0. Written values are masked to 7 bits (seconds, minutes), 6 bits (hours, day), 5 bits (month), 8 bits (year bytes) and 3 bits (weekday).
- R4: A counting tick adds one second. Seconds and minutes wrap 59 to 00 with carry, hours wrap 23 to 00 with carry, and the weekday counts 0 to 6 and wraps on each day carry.
- R5: The day wraps to 01 after the last day of the month (30 for months 04, 06, 09 and 11, otherwise 31 except February). Month 12 wraps to 01. Year-low 99 wraps to 00 and carries into year-high.
- R6: February has 29 days when the year is a leap year. For a nonzero low byte the rule is low divisible by 4. For a low byte of 00 the rule is high divisible by 4, so 2000 is a leap year and 2100 is not.
- R7: Writing control bit 6 as 1 copies the live time into the shadow set. While control bit 7 is 1, the time offsets read the shadow set; otherwise they read the live time.
- R8: Alarm pending (bit 4 of offset 0x40) is set on a counting tick whose new time equals all seven alarm fields. It is set once per match.
- R9: Writing 1 to bit 4 of offset 0x40 clears the pending bit. `irq` equals pending AND bit 7 of offset 0x48.
- R10: After reset the time is 2000-01-01 00:00:00 with weekday 0. Control, status, enables and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Key in bits 31:8, data in bits 7:0 |
| bus_rdata | output | 32 | Read data, zero above bit 7 |
| irq | output | 1 | Alarm interrupt |

## Verification
A wrong carry decision inside the next-time logic shows up at the time offsets on the very tick that crosses the boundary. The vectors therefore start one second before each month, leap and century edge and read back right after that tick. A run-status register that lags or leads the control bit shows as a missing or an extra second two ticks after a start. A stale shadow or a pending bit that is never set shows on the first read after the snapshot or match. A pending bit that is set twice shows on the read after the next tick.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int SEC_W  = 7;
  localparam int MIN_W  = 7;
  localparam int HR_W   = 6;
  localparam int DAY_W  = 6;
  localparam int MON_W  = 5;
  localparam int YR_W   = 8;
  localparam int WDAY_W = 3;

  typedef struct packed {
    logic [SEC_W-1:0]  sec;
    logic [MIN_W-1:0]  min;
    logic [HR_W-1:0]   hr;
    logic [DAY_W-1:0]  day;
    logic [MON_W-1:0]  mon;
    logic [YR_W-1:0]   yl;
    logic [YR_W-1:0]   yh;
    logic [WDAY_W-1:0] wday;
  } cal_t;

  typedef struct packed {
    logic [SEC_W-1:0]  sec;
    logic [MIN_W-1:0]  min;
    logic [HR_W-1:0]   hr;
    logic [DAY_W-1:0]  day;
    logic [MON_W-1:0]  mon;
    logic [YR_W-1:0]   yl;
    logic [YR_W-1:0]   yh;
  } alm_t;

  localparam cal_t CAL_RESET = '{sec: '0, min: '0, hr: '0, day: 6'h01,
                                 mon: 5'h01, yl: 8'h00, yh: 8'h20, wday: '0};

  // value of a two-digit BCD byte modulo 4: 10*t + u == 2*t[0] + u (mod 4)
  function automatic logic [1:0] bcd_mod4(input logic [7:0] v);
    return {v[4], 1'b0} + v[1:0];
  endfunction
endpackage

// File: rtl/rtc_next_time.sv
module rtc_next_time
  import rtc_cal_pkg::*;
(
  input  cal_t cur,
  output cal_t nxt
);
  logic       leap;
  logic [5:0] last_day;
  logic       c_min, c_hr, c_day, c_mon, c_yr, c_cen;

  always_comb begin
    leap = (cur.yl == 8'h00) ? (bcd_mod4(cur.yh) == 2'd0)
                             : (bcd_mod4(cur.yl) == 2'd0);
    case (cur.mon)
      5'h02:                      last_day = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_day = 6'h30;
      default:                    last_day = 6'h31;
    endcase
    c_min = cur.sec >= 7'h59;
    c_hr  = c_min && (cur.min >= 7'h59);
    c_day = c_hr  && (cur.hr  >= 6'h23);
    c_mon = c_day && (cur.day >= last_day);
    c_yr  = c_mon && (cur.mon >= 5'h12);
    c_cen = c_yr  && (cur.yl  >= 8'h99);

    nxt = cur;
    nxt.sec = c_min ? '0 : ((cur.sec[3:0] >= 4'd9) ? {cur.sec[6:4] + 3'd1, 4'd0}
                                                  : cur.sec + 7'd1);
    if (c_min)
      nxt.min = c_hr ? '0 : ((cur.min[3:0] >= 4'd9) ? {cur.min[6:4] + 3'd1, 4'd0}
                                                   : cur.min + 7'd1);
    if (c_hr)
      nxt.hr = c_day ? '0 : ((cur.hr[3:0] >= 4'd9) ? {cur.hr[5:4] + 2'd1, 4'd0}
                                                  : cur.hr + 6'd1);
    if (c_day) begin
      nxt.day  = c_mon ? 6'h01 : ((cur.day[3:0] >= 4'd9) ? {cur.day[5:4] + 2'd1, 4'd0}
                                                         : cur.day + 6'd1);
      nxt.wday = (cur.wday >= 3'd6) ? 3'd0 : cur.wday + 3'd1;
    end
    if (c_mon)
      nxt.mon = c_yr ? 5'h01 : ((cur.mon[3:0] >= 4'd9) ? {cur.mon[4] + 1'b1, 4'd0}
                                                      : cur.mon + 5'd1);
    if (c_yr)
      nxt.yl = c_cen ? 8'h00 : ((cur.yl[3:0] >= 4'd9) ? {cur.yl[7:4] + 4'd1, 4'd0}
                                                     : cur.yl + 8'd1);
    if (c_cen)
      nxt.yh = (cur.yh >= 8'h99) ? 8'h00
             : ((cur.yh[3:0] >= 4'd9) ? {cur.yh[7:4] + 4'd1, 4'd0} : cur.yh + 8'd1);
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_cal_pkg::*;
#(
  parameter int FIELDS = 7
) (
  input  alm_t now,
  input  alm_t target,
  output logic hit
);
  localparam int W = $bits(alm_t);
  logic [W-1:0] diff;
  assign diff = now ^ target;
  assign hit  = (diff == '0) && (FIELDS > 0);
endmodule

// File: rtl/bcd_calendar_rtc.sv
module bcd_calendar_rtc
  import rtc_cal_pkg::*;
#(
  parameter logic [23:0] WRITE_KEY = 24'hC45229,
  parameter int          ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int IDX_W     = ADDR_W - 2;
  localparam int IDX_ALM   = 8;
  localparam int IDX_CTRL  = 15;
  localparam int IDX_STAT0 = 16;
  localparam int IDX_STAT1 = 17;
  localparam int IDX_INTEN = 18;
  localparam int PEND_BIT  = 4;
  localparam int AEN_BIT   = 7;

  cal_t       live, shadow, nxt;
  alm_t       alarm;
  logic       ctrl_run, ctrl_rsel, run_st, alm_pend, match;
  logic [7:0] int_en;

  logic [IDX_W-1:0] idx;
  logic [7:0]       wd;
  logic             wr_ok, step, time_wr;

  assign idx     = bus_addr[ADDR_W-1:2];
  assign wd      = bus_wdata[7:0];
  assign wr_ok   = bus_wr && (bus_wdata[31:8] == WRITE_KEY) && (bus_addr[1:0] == 2'b00);
  assign step    = tick_1hz && run_st;
  assign time_wr = wr_ok && (idx < IDX_W'(IDX_ALM));

  rtc_next_time u_next (.cur(live), .nxt(nxt));

  rtc_alarm_cmp #(.FIELDS(7)) u_cmp (
    .now   ('{sec: nxt.sec, min: nxt.min, hr: nxt.hr, day: nxt.day,
              mon: nxt.mon, yl: nxt.yl, yh: nxt.yh}),
    .target(alarm),
    .hit   (match)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live      <= CAL_RESET;
      shadow    <= CAL_RESET;
      alarm     <= '0;
      ctrl_run  <= 1'b0;
      ctrl_rsel <= 1'b0;
      run_st    <= 1'b0;
      alm_pend  <= 1'b0;
      int_en    <= '0;
    end else begin
      if (tick_1hz) run_st <= ctrl_run;
      if (step) live <= nxt;
      else if (time_wr && !run_st) begin
        case (idx[2:0])
          3'd0: live.sec  <= wd[6:0];
          3'd1: live.min  <= wd[6:0];
          3'd2: live.hr   <= wd[5:0];
          3'd3: live.day  <= wd[5:0];
          3'd4: live.mon  <= wd[4:0];
          3'd5: live.yl   <= wd;
          3'd6: live.yh   <= wd;
          default: live.wday <= wd[2:0];
        endcase
      end
      if (wr_ok) begin
        case (idx)
          IDX_W'(IDX_ALM):     alarm.sec <= wd[6:0];
          IDX_W'(IDX_ALM + 1): alarm.min <= wd[6:0];
          IDX_W'(IDX_ALM + 2): alarm.hr  <= wd[5:0];
          IDX_W'(IDX_ALM + 3): alarm.day <= wd[5:0];
          IDX_W'(IDX_ALM + 4): alarm.mon <= wd[4:0];
          IDX_W'(IDX_ALM + 5): alarm.yl  <= wd;
          IDX_W'(IDX_ALM + 6): alarm.yh  <= wd;
          IDX_W'(IDX_CTRL): begin
            ctrl_run  <= wd[0];
            ctrl_rsel <= wd[7];
            if (wd[6]) shadow <= live;
          end
          IDX_W'(IDX_INTEN): int_en <= wd;
          default: ;
        endcase
      end
      if (step && match) alm_pend <= 1'b1;
      else if (wr_ok && (idx == IDX_W'(IDX_STAT0)) && wd[PEND_BIT]) alm_pend <= 1'b0;
    end
  end

  assign irq = alm_pend && int_en[AEN_BIT];

  function automatic logic [7:0] field_of(input cal_t t, input logic [2:0] i);
    case (i)
      3'd0:    return 8'(t.sec);
      3'd1:    return 8'(t.min);
      3'd2:    return 8'(t.hr);
      3'd3:    return 8'(t.day);
      3'd4:    return 8'(t.mon);
      3'd5:    return t.yl;
      3'd6:    return t.yh;
      default: return 8'(t.wday);
    endcase
  endfunction

  logic [7:0] rd8;
  always_comb begin
    rd8 = '0;
    if (bus_addr[1:0] == 2'b00) begin
      if (idx < IDX_W'(IDX_ALM)) rd8 = field_of(ctrl_rsel ? shadow : live, idx[2:0]);
      else case (idx)
        IDX_W'(IDX_ALM):     rd8 = 8'(alarm.sec);
        IDX_W'(IDX_ALM + 1): rd8 = 8'(alarm.min);
        IDX_W'(IDX_ALM + 2): rd8 = 8'(alarm.hr);
        IDX_W'(IDX_ALM + 3): rd8 = 8'(alarm.day);
        IDX_W'(IDX_ALM + 4): rd8 = 8'(alarm.mon);
        IDX_W'(IDX_ALM + 5): rd8 = alarm.yl;
        IDX_W'(IDX_ALM + 6): rd8 = alarm.yh;
        IDX_W'(IDX_CTRL):    rd8 = {ctrl_rsel, 6'd0, ctrl_run};
        IDX_W'(IDX_STAT0):   rd8 = 8'(alm_pend) << PEND_BIT;
        IDX_W'(IDX_STAT1):   rd8 = {7'd0, run_st};
        IDX_W'(IDX_INTEN):   rd8 = int_en;
        default:             rd8 = '0;
      endcase
    end
  end
  assign bus_rdata = {24'd0, rd8};

  // R1: a write with a wrong key or alignment leaves the control state untouched
  assert_key_guard_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !wr_ok) |=> ($stable(ctrl_run) && $stable(ctrl_rsel) &&
                            $stable(int_en) && $stable(alarm)));

  // R2: run status copies the run bit at each tick
  assert_status_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1hz |=> (run_st == $past(ctrl_run)));

  // R3: with the counter stopped and no time write, the live time holds
  assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_st && !time_wr) |=> $stable(live));

  // R4: every counting tick changes the seconds field
  assert_sec_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (live.sec != $past(live.sec)));

  // R8: the pending bit only rises on a counting tick
  assert_alarm_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alm_pend) |-> $past(step));

  // R9: a clearing write without a coincident match drops pending
  assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && idx == IDX_W'(IDX_STAT0) && wd[PEND_BIT] && !step) |=> !alm_pend);
endmodule

// File: tb/sim_bcd_calendar_rtc.sv
module sim_bcd_calendar_rtc;
  localparam logic [23:0] KEY = 24'hC45229;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1hz = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bcd_calendar_rtc u0 (.clk, .rst_n, .tick_1hz, .bus_wr, .bus_addr,
                       .bus_wdata, .bus_rdata, .irq);

  // {start sec,min,hr,day,mon,yl,yh,wday ; expected after one counting tick}
  localparam logic [127:0] VEC [10] = '{
    128'h56341215_03242002_57341215_03242002,  // R4 plain second
    128'h59592331_12992006_00000001_01002100,  // R5 year and century carry
    128'h59592328_02232001_00000001_03232002,  // R6 2023 not leap
    128'h59592328_02242003_00000029_02242004,  // R6 2024 leap
    128'h59592328_02002105_00000001_03002106,  // R6 2100 not leap
    128'h59592328_02002001_00000029_02002002,  // R6 2000 leap
    128'h59592330_04242002_00000001_05242003,  // R5 30-day month
    128'h59590010_01252005_00000110_01252005,  // R4 hour carry
    128'h59592329_02242004_00000001_03242005,  // R5 end of leap February
    128'h59230907_08252004_00240907_08252004   // R4 minute carry
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_key(input logic [7:0] a, input logic [23:0] k, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = {k, d};
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_key(a, KEY, d);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata[7:0];
  endtask

  task automatic tick();
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
  endtask

  task automatic load_time(input logic [63:0] t);
    for (int i = 0; i < 8; i++) wr(8'(i * 4), t[63 - 8 * i -: 8]);
  endtask

  task automatic read_time(output logic [63:0] t);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) begin
      rd(8'(i * 4), b);
      t[63 - 8 * i -: 8] = b;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete (actual hung, expected done)");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  v;
    logic [63:0] t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state
    read_time(t);
    chk("R10 reset time", t, 64'h00000001_01002000);
    rd(8'h3C, v); chk("R10 control", 64'(v), 64'h0);
    rd(8'h44, v); chk("R10 run status", 64'(v), 64'h0);
    chk("R10 irq", 64'(irq), 64'h0);

    // R1: writes with a wrong key or misaligned address are dropped
    wr_key(8'h48, 24'hC45228, 8'hFF);
    rd(8'h48, v); chk("R1 bad key enable", 64'(v), 64'h0);
    wr_key(8'h3C, 24'h000000, 8'h01);
    tick();
    rd(8'h44, v); chk("R1 bad key run", 64'(v), 64'h0);
    wr(8'h49, 8'hFF);
    rd(8'h48, v); chk("R1 misaligned", 64'(v), 64'h0);

    // R4 R5 R6: rollover vectors
    for (int k = 0; k < 10; k++) begin
      load_time(VEC[k][127:64]);
      wr(8'h3C, 8'h01);
      tick();
      tick();
      read_time(t);
      chk($sformatf("R4 R5 R6 vector %0d", k), t, VEC[k][63:0]);
      wr(8'h3C, 8'h00);
      tick();
    end

    // R2 R3 R8 R9 directed sequence
    load_time(64'h30201005_06242003);
    wr(8'h20, 8'h32); wr(8'h24, 8'h20); wr(8'h28, 8'h10); wr(8'h2C, 8'h05);
    wr(8'h30, 8'h06); wr(8'h34, 8'h24); wr(8'h38, 8'h20);
    wr(8'h48, 8'h80);
    wr(8'h3C, 8'h01);
    rd(8'h44, v); chk("R2 status before tick", 64'(v), 64'h0);
    tick();
    rd(8'h44, v); chk("R2 status after tick", 64'(v), 64'h1);
    rd(8'h00, v); chk("R2 no step on start tick", 64'(v), 64'h30);
    tick();
    rd(8'h00, v); chk("R2 first step", 64'(v), 64'h31);
    rd(8'h40, v); chk("R8 no early pending", 64'(v), 64'h0);
    wr(8'h00, 8'h45);
    rd(8'h00, v); chk("R3 write while running ignored", 64'(v), 64'h31);
    tick();
    rd(8'h40, v); chk("R8 pending on match", 64'(v), 64'h10);
    chk("R9 irq on pending", 64'(irq), 64'h1);
    tick();
    rd(8'h40, v); chk("R8 still pending", 64'(v), 64'h10);
    wr(8'h40, 8'h10);
    rd(8'h40, v); chk("R9 clear", 64'(v), 64'h0);
    chk("R9 irq cleared", 64'(irq), 64'h0);
    tick();
    rd(8'h40, v); chk("R8 once per match", 64'(v), 64'h0);

    // R7: snapshot at 34, live runs to 36
    wr(8'h3C, 8'hC1);
    tick(); tick();
    rd(8'h00, v); chk("R7 shadow read", 64'(v), 64'h34);
    wr(8'h3C, 8'h01);
    rd(8'h00, v); chk("R7 live read", 64'(v), 64'h36);

    // R2: stop takes effect on the next tick
    wr(8'h3C, 8'h00);
    rd(8'h44, v); chk("R2 still running", 64'(v), 64'h1);
    tick();
    rd(8'h44, v); chk("R2 stopped", 64'(v), 64'h0);
    rd(8'h00, v); chk("R2 last step", 64'(v), 64'h37);
    tick();
    rd(8'h00, v); chk("R2 held while stopped", 64'(v), 64'h37);

    // R3: masking of field widths
    wr(8'h08, 8'hFF);
    rd(8'h08, v); chk("R3 hour mask", 64'(v), 64'h3F);
    wr(8'h1C, 8'hFF);
    rd(8'h1C, v); chk("R3 weekday mask", 64'(v), 64'h07);

    // R9: pending without enable gives no irq
    wr(8'h48, 8'h00);
    load_time(64'h31201005_06242003);
    wr(8'h3C, 8'h01);
    tick(); tick();
    rd(8'h40, v); chk("R8 second match", 64'(v), 64'h10);
    chk("R9 irq gated off", 64'(irq), 64'h0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule